// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block converts the address operands of a memory instruction into a checked linear address. An offset is formed from an optional base register, an optional index register shifted left by a 2-bit scale code, and a displacement. The displacement is absent, an 8-bit signed value, or a full 32-bit value. A 16-bit segment selector picks one of two cached descriptors, global or local. The segment base in that descriptor is added to the offset to form the linear address.

Each accepted request is checked against the chosen descriptor. The request faults on a null selector, on an offset above the segment limit, or on a write to a segment that does not permit writes. A faulting request raises a one-cycle fault pulse in place of the output valid. Every result appears on registered outputs one clock after the input is presented. The block accepts a new request on every cycle.

Top module: `seg_addr_gen`

## Requirements
- R1: The effective offset is the sum of the base term, the scaled index term and the displacement term, modulo 2^32. The linear address is the segment base plus the effective offset, also modulo 2^32.
- R2: The scale code `scale_code` is a left shift of 0, 1, 2 or 3 bits applied to the index, giving a factor of 1, 2, 4 or 8.
- R3: A `disp_size` of 0 gives a zero displacement. A value of 1 uses `disp[7:0]` sign-extended to 32 bits and ignores the upper bits. A value of 2 or 3 uses all 32 bits of `disp`.
- R4: The selector fields are fixed: `sel[1:0]` is the requested privilege level, `sel[2]` is the table bit and `sel[15:3]` is the table index. A table bit of 0 selects the global descriptor inputs and 1 selects the local descriptor inputs.
- R5: `rpl` shows `sel[1:0]` of the request accepted on the previous cycle (0 is the most privileged level, 3 the least).
- R6: The request faults when the offset is greater than the selected limit. An offset equal to the limit is accepted.
- R7: A selector whose index and table bit are all zero (`sel[15:2]` = 0) always faults, whatever its privilege bits are. Index 0 with the table bit at 1 does not fault for this reason.
- R8: A write (`is_write` = 1) faults when the selected descriptor's write-permit input is 0. A read never faults for this reason.
- R9: One cycle after `in_valid` is high, exactly one of `out_valid` and `fault` is high: `fault` when any check of R6 to R8 fails, `out_valid` otherwise. When `in_valid` was low the cycle before, both are low.
- R10: When `base_en` is 0 the base term is zero. When `idx_en` is 0 the index term is zero.
- R11: While reset is asserted and right after it, `out_valid` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| sel | input | 16 | Segment selector |
| base_val | input | 32 | Base register value |
| base_en | input | 1 | Base term enable |
| idx_val | input | 32 | Index register value |
| idx_en | input | 1 | Index term enable |
| scale_code | input | 2 | Index shift amount |
| disp | input | 32 | Displacement from the instruction |
| disp_size | input | 2 | Displacement form: 0 none, 1 8-bit, 2 or 3 32-bit |
| is_write | input | 1 | Request is a write access |
| gdt_base | input | 32 | Global descriptor segment base |
| gdt_limit | input | 32 | Global descriptor segment limit |
| gdt_wr | input | 1 | Global descriptor permits writes |
| ldt_base | input | 32 | Local descriptor segment base |
| ldt_limit | input | 32 | Local descriptor segment limit |
| ldt_wr | input | 1 | Local descriptor permits writes |
| out_valid | output | 1 | Result valid and without fault |
| eff_ofs | output | 32 | Effective offset |
| lin_addr | output | 32 | Linear address |
| rpl | output | 2 | Requested privilege level of the result |
| fault | output | 1 | Request was rejected by a check |

## Verification
The offset path is driven with each scale code on a fixed index and with each displacement form. Negative 8-bit displacements with nonzero upper bits show whether sign extension and masking are right. Sums that overflow 32 bits show whether the result wraps. Requests that differ only in the table bit, with the two descriptors given different bases, show which descriptor was chosen. Offsets set exactly at the limit and one above it pin down the comparison edge. Null selectors, index 0 with the local table, and reads and writes against both write-permit settings separate the three fault causes from one another.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned SEL_W    = 16;
    localparam int unsigned RPL_W    = 2;
    localparam int unsigned DISP8_W  = 8;
    localparam int unsigned SCALE_W  = 2;
    localparam int unsigned DSZ_W    = 2;

    localparam logic [DSZ_W-1:0] DSZ_NONE = 2'd0;
    localparam logic [DSZ_W-1:0] DSZ_B8   = 2'd1;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic              wr_ok;
    } desc_t;

    typedef struct packed {
        logic              vld;
        logic              flt;
        logic [ADDR_W-1:0] ofs;
        logic [ADDR_W-1:0] lin;
        logic [RPL_W-1:0]  rpl;
    } stage_t;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
    import seg_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned SW  = SCALE_W,
    parameter int unsigned D8W = DISP8_W
) (
    input  logic [AW-1:0]    base_val,
    input  logic             base_en,
    input  logic [AW-1:0]    idx_val,
    input  logic             idx_en,
    input  logic [SW-1:0]    scale_code,
    input  logic [AW-1:0]    disp,
    input  logic [DSZ_W-1:0] disp_size,
    output logic [AW-1:0]    ofs
);
    localparam int unsigned EXT_W = AW - D8W;

    logic [AW-1:0] base_term;
    logic [AW-1:0] idx_term;
    logic [AW-1:0] disp_term;

    always_comb begin
        base_term = base_en ? base_val : '0;
        idx_term  = idx_en ? (idx_val << scale_code) : '0;
        case (disp_size)
            DSZ_NONE: disp_term = '0;
            DSZ_B8:   disp_term = {{EXT_W{disp[D8W-1]}}, disp[D8W-1:0]};
            default:  disp_term = disp;
        endcase
        ofs = base_term + idx_term + disp_term;
    end
endmodule

// File: rtl/seg_desc_pick.sv
module seg_desc_pick
    import seg_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SLW = SEL_W,
    parameter int unsigned RW = RPL_W
) (
    input  logic [SLW-1:0] sel,
    input  desc_t          glb,
    input  desc_t          loc,
    output desc_t          chosen,
    output logic [RW-1:0]  req_pl,
    output logic           null_sel
);
    localparam int unsigned TI_POS = RW;
    localparam int unsigned IDX_W  = SLW - RW - 1;

    logic [IDX_W-1:0] tbl_idx;
    logic             tbl_bit;
    desc_t            tbl [2];

    always_comb begin
        req_pl   = sel[RW-1:0];
        tbl_bit  = sel[TI_POS];
        tbl_idx  = sel[SLW-1:TI_POS+1];
        tbl[0]   = glb;
        tbl[1]   = loc;
        chosen   = tbl[tbl_bit];
        null_sel = (tbl_idx == '0) && !tbl_bit;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [SEL_W-1:0]   sel,
    input  logic [AW-1:0]      base_val,
    input  logic               base_en,
    input  logic [AW-1:0]      idx_val,
    input  logic               idx_en,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [AW-1:0]      disp,
    input  logic [DSZ_W-1:0]   disp_size,
    input  logic               is_write,
    input  logic [AW-1:0]      gdt_base,
    input  logic [AW-1:0]      gdt_limit,
    input  logic               gdt_wr,
    input  logic [AW-1:0]      ldt_base,
    input  logic [AW-1:0]      ldt_limit,
    input  logic               ldt_wr,
    output logic               out_valid,
    output logic [AW-1:0]      eff_ofs,
    output logic [AW-1:0]      lin_addr,
    output logic [RPL_W-1:0]   rpl,
    output logic               fault
);
    logic [AW-1:0]    ofs_c;
    desc_t            glb_c, loc_c, dsc_c;
    logic [RPL_W-1:0] pl_c;
    logic             null_c;
    logic             bad_c;
    stage_t           st_d, st_q;

    assign glb_c = '{base: gdt_base, limit: gdt_limit, wr_ok: gdt_wr};
    assign loc_c = '{base: ldt_base, limit: ldt_limit, wr_ok: ldt_wr};

    ea_offset_calc #(.AW(AW)) u_ofs (
        .base_val  (base_val),
        .base_en   (base_en),
        .idx_val   (idx_val),
        .idx_en    (idx_en),
        .scale_code(scale_code),
        .disp      (disp),
        .disp_size (disp_size),
        .ofs       (ofs_c)
    );

    seg_desc_pick #(.AW(AW)) u_pick (
        .sel     (sel),
        .glb     (glb_c),
        .loc     (loc_c),
        .chosen  (dsc_c),
        .req_pl  (pl_c),
        .null_sel(null_c)
    );

    always_comb begin
        bad_c = null_c || (ofs_c > dsc_c.limit) || (is_write && !dsc_c.wr_ok);
        st_d  = st_q;
        st_d.vld = in_valid && !bad_c;
        st_d.flt = in_valid && bad_c;
        if (in_valid) begin
            st_d.ofs = ofs_c;
            st_d.lin = dsc_c.base + ofs_c;
            st_d.rpl = pl_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign fault     = st_q.flt;
    assign eff_ofs   = st_q.ofs;
    assign lin_addr  = st_q.lin;
    assign rpl       = st_q.rpl;

    // R9
    valid_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && fault));

    // R9
    one_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid || fault));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !fault));

    // R5
    rpl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rpl == $past(sel[RPL_W-1:0])));

    // R6
    within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_valid ||
            eff_ofs <= $past(sel[RPL_W] ? ldt_limit : gdt_limit)));

    // R7
    null_sel_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel[SEL_W-1:RPL_W] == '0) |=> fault);

    // R4
    lin_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_valid ||
            lin_addr == $past(sel[RPL_W] ? ldt_base : gdt_base) + eff_ofs));
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] sel = '0;
    logic [31:0] base_val = '0;
    logic        base_en = 1'b0;
    logic [31:0] idx_val = '0;
    logic        idx_en = 1'b0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp = '0;
    logic [1:0]  disp_size = '0;
    logic        is_write = 1'b0;
    logic [31:0] gdt_base = '0, gdt_limit = '0;
    logic        gdt_wr = 1'b0;
    logic [31:0] ldt_base = '0, ldt_limit = '0;
    logic        ldt_wr = 1'b0;
    logic        out_valid, fault;
    logic [31:0] eff_ofs, lin_addr;
    logic [1:0]  rpl;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel(sel),
        .base_val(base_val), .base_en(base_en), .idx_val(idx_val), .idx_en(idx_en),
        .scale_code(scale_code), .disp(disp), .disp_size(disp_size), .is_write(is_write),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit), .gdt_wr(gdt_wr),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit), .ldt_wr(ldt_wr),
        .out_valid(out_valid), .eff_ofs(eff_ofs), .lin_addr(lin_addr),
        .rpl(rpl), .fault(fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_defaults();
        sel = 16'h0008; base_val = '0; base_en = 1'b0; idx_val = '0; idx_en = 1'b0;
        scale_code = '0; disp = '0; disp_size = 2'd0; is_write = 1'b0;
        gdt_base = 32'h0001_0000; gdt_limit = 32'hFFFF_FFFF; gdt_wr = 1'b1;
        ldt_base = 32'h0050_0000; ldt_limit = 32'hFFFF_FFFF; ldt_wr = 1'b1;
    endtask

    // Inputs are set at a falling edge; the result is sampled at the next falling edge.
    task automatic issue(input string tag, input bit exp_flt,
                         input logic [31:0] exp_ofs, input logic [31:0] exp_lin);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " out_valid"}, {31'b0, out_valid}, {31'b0, !exp_flt});
        chk({tag, " fault"}, {31'b0, fault}, {31'b0, exp_flt});
        chk({tag, " rpl"}, {30'b0, rpl}, {30'b0, sel[1:0]});
        if (!exp_flt) begin
            chk({tag, " eff_ofs"}, eff_ofs, exp_ofs);
            chk({tag, " lin_addr"}, lin_addr, exp_lin);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 reset out_valid", {31'b0, out_valid}, 32'd0);
        chk("R11 reset fault", {31'b0, fault}, 32'd0);
    endtask

    task automatic t_basic();
        set_defaults();
        sel = 16'h000A; base_val = 32'h1000; base_en = 1'b1;
        idx_val = 32'h10; idx_en = 1'b1; scale_code = 2'd2;
        disp = 32'h20; disp_size = 2'd2;
        issue("R1 R5 basic", 1'b0, 32'h1060, 32'h0001_1060);
    endtask

    task automatic t_scales();
        for (int s = 0; s < 4; s++) begin
            set_defaults();
            idx_val = 32'h3; idx_en = 1'b1; scale_code = s[1:0];
            sel = 16'h0008 | 16'(s);
            issue("R2 scale", 1'b0, 32'h3 << s, 32'h0001_0000 + (32'h3 << s));
        end
    endtask

    task automatic t_disp();
        set_defaults();
        base_val = 32'h200; base_en = 1'b1;
        disp = 32'h1234_5680; disp_size = 2'd1;
        issue("R3 disp8 negative", 1'b0, 32'h180, 32'h0001_0180);
        disp = 32'h0000_007F; disp_size = 2'd1;
        issue("R3 disp8 positive", 1'b0, 32'h27F, 32'h0001_027F);
        disp = 32'h1234_5680; disp_size = 2'd0;
        issue("R3 disp none", 1'b0, 32'h200, 32'h0001_0200);
        disp_size = 2'd3;
        issue("R3 disp32 code3", 1'b0, 32'h1234_5880, 32'h1235_5880);
    endtask

    task automatic t_enables();
        set_defaults();
        base_val = 32'hDEAD_0000; base_en = 1'b0;
        idx_val = 32'h40; idx_en = 1'b1; scale_code = 2'd1;
        issue("R10 base off", 1'b0, 32'h80, 32'h0001_0080);
        base_en = 1'b1; base_val = 32'h44; idx_en = 1'b0;
        issue("R10 idx off", 1'b0, 32'h44, 32'h0001_0044);
    endtask

    task automatic t_wrap();
        set_defaults();
        base_val = 32'hFFFF_FFF0; base_en = 1'b1; disp = 32'h20; disp_size = 2'd2;
        issue("R1 offset wrap", 1'b0, 32'h10, 32'h0001_0010);
        base_val = 32'h200; disp_size = 2'd0; gdt_base = 32'hFFFF_FF00;
        issue("R1 linear wrap", 1'b0, 32'h200, 32'h0000_0100);
    endtask

    task automatic t_tables();
        set_defaults();
        base_val = 32'h30; base_en = 1'b1;
        sel = 16'h000D;
        issue("R4 local table", 1'b0, 32'h30, 32'h0050_0030);
        sel = 16'h0004;
        issue("R7 R4 index0 local", 1'b0, 32'h30, 32'h0050_0030);
        sel = 16'h0009;
        issue("R4 global table", 1'b0, 32'h30, 32'h0001_0030);
    endtask

    task automatic t_limit();
        set_defaults();
        base_val = 32'h0FFF; base_en = 1'b1; gdt_limit = 32'h0FFF;
        issue("R6 at limit", 1'b0, 32'h0FFF, 32'h0001_0FFF);
        base_val = 32'h1000;
        issue("R6 over limit", 1'b1, 32'h0, 32'h0);
        sel = 16'h000C; ldt_limit = 32'h0800;
        issue("R6 local over limit", 1'b1, 32'h0, 32'h0);
    endtask

    task automatic t_null();
        set_defaults();
        sel = 16'h0003;
        issue("R7 null rpl3", 1'b1, 32'h0, 32'h0);
        sel = 16'h0000;
        issue("R7 null rpl0", 1'b1, 32'h0, 32'h0);
    endtask

    task automatic t_write();
        set_defaults();
        gdt_wr = 1'b0; is_write = 1'b1;
        issue("R8 write denied", 1'b1, 32'h0, 32'h0);
        is_write = 1'b0;
        issue("R8 read allowed", 1'b0, 32'h0, 32'h0001_0000);
        gdt_wr = 1'b1; is_write = 1'b1;
        issue("R8 write allowed", 1'b0, 32'h0, 32'h0001_0000);
        sel = 16'h000C; ldt_wr = 1'b0;
        issue("R8 local write denied", 1'b1, 32'h0, 32'h0);
    endtask

    task automatic t_idle();
        set_defaults();
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R9 idle fault", {31'b0, fault}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_scales();
        t_disp();
        t_enables();
        t_wrap();
        t_tables();
        t_limit();
        t_null();
        t_write();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule